// File: doc/BRIEF.md
# Memory Bank Sizing Register Block

This block is the software-facing side of a memory controller with six module sockets. Firmware learns from two read-only ports which sockets carry a module and which of those modules are large. It then lays out the physical address map by writing bank end addresses, in 8 MB units, through a single auto-indexed size port. Every write holds a 3-bit slot number and a 5-bit end value. A write to slot k (1 to 6) recomputes the base address and the enable of socket k-1 from the end value held in the slot below. A fixed status port reports that no parity error was detected.

The static per-socket straps give the fitted module: empty, 8 MB or 32 MB. Modules are fitted in matched pairs. A registered address decoder uses the programmed bases, enables and module sizes to say which socket a physical address falls into.

Top module: `mem_bank_sizer`

## Requirements
- R1: A read of port 0x803 returns a byte whose bit n (n = 0..5) is 1 exactly when socket n holds a 32 MB module (strap 2'b10); bits 6 and 7 read 0.
- R2: A read of port 0x804 returns a byte whose bit n is 0 exactly when socket n is populated (strap 2'b01 = 8 MB or 2'b10 = 32 MB); bits 6 and 7 read 1. Straps 2'b00 and 2'b11 count as empty.
- R3: Any read of port 0x804 returns the size-port read pointer to slot 0.
- R4: A read of port 0x820 returns the 5-bit end value of the slot under the read pointer, zero-extended, then advances the pointer by one. Slot 7 wraps to slot 0.
- R5: A write to port 0x820 stores data bits [4:0] into the slot selected by data bits [7:5]. All eight slots are stored.
- R6: A write to slot k, 1 <= k <= 6, on a populated socket k-1 sets that socket's base to the start value: 0 when k = 1, otherwise the end value in slot k-1. The socket is enabled only when the written end differs from that start. Base and enable show the new values one cycle after the write.
- R7: Writes to slot 0 or slot 7 change no socket's base or enable. A write aimed at an empty socket also leaves that socket's base and enable unchanged.
- R8: A read of port 0x841 always returns 0x01.
- R9: Reads of any other port return 0x00. Writes to ports 0x803, 0x804, 0x841 or unmapped ports change no slot, no socket and no read pointer.
- R10: Synchronous active-high reset clears all slots, the read pointer, the read data, every base, every enable and the hit outputs.
- R11: One cycle after an address is presented, hit_valid is 1 when some enabled socket n satisfies base <= addr/8MB < base + size (1 unit for 8 MB, 4 units for 32 MB), and hit_socket names the highest-numbered such socket.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 12 | I/O port address |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data, valid the cycle after io_rd |
| socket_kind | input | 12 | Two bits per socket: 00 empty, 01 8 MB, 10 32 MB, 11 empty |
| lookup_addr | input | 28 | Physical byte address to decode |
| bank_base | output | 30 | Five bits per socket: base in 8 MB units |
| bank_en | output | 6 | One bit per socket: bank enabled |
| hit_valid | output | 1 | Registered: lookup address falls in an enabled bank |
| hit_socket | output | 3 | Registered: socket number of the hit |

## Verification
The bench walks the read pointer through all eight slots and past the wrap. It then clears the pointer partway through a walk with a presence read. A design that forgets the wrap, or that clears the pointer on the wrong port, returns the wrong slot order. Programming covers a bank whose end equals its start, which must stay disabled, and writes to slots 0 and 7 and to an empty socket, none of which may disturb a bank. A design that keys the start on slot 0 for k = 1 shows up as a wrong socket 0 base. The decoder is probed on the last unit of a 32 MB bank and on the first unit of the next one, and on an overlap in which the higher socket must win. A reversed priority, or an off-by-one bank size, names the wrong socket.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  typedef enum logic [1:0] {
    MOD_NONE  = 2'b00,
    MOD_SMALL = 2'b01,
    MOD_LARGE = 2'b10,
    MOD_RSVD  = 2'b11
  } mod_kind_e;

  function automatic logic kind_present(input logic [1:0] k);
    return (k == MOD_SMALL) || (k == MOD_LARGE);
  endfunction

  function automatic logic kind_large(input logic [1:0] k);
    return k == MOD_LARGE;
  endfunction

  // module size in 8 MB units
  function automatic logic [2:0] kind_units(input logic [1:0] k);
    case (k)
      MOD_SMALL: return 3'd1;
      MOD_LARGE: return 3'd4;
      default:   return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/mbs_slot_table.sv
module mbs_slot_table #(
  parameter int IDX_W = 3,
  parameter int END_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [END_W-1:0] wr_end,
  input  logic             ptr_clr,
  input  logic             ptr_step,
  output logic [END_W-1:0] ptr_end,
  output logic [END_W-1:0] start_end
);
  localparam int SLOTS = 1 << IDX_W;

  logic [END_W-1:0] slots [SLOTS];
  logic [IDX_W-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) slots[i] <= '0;
    end else if (wr_en) begin
      slots[wr_idx] <= wr_end;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           ptr <= '0;
    else if (ptr_clr)  ptr <= '0;
    else if (ptr_step) ptr <= ptr + 1'b1;
  end

  assign ptr_end   = slots[ptr];
  assign start_end = (wr_idx > IDX_W'(1)) ? slots[wr_idx - 1'b1] : '0;

  assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (rst)
    ptr_clr |=> ptr == '0)
    else $error("read pointer not cleared");

  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (rst)
    (ptr_step && !ptr_clr) |=> ptr == IDX_W'($past(ptr) + 1'b1))
    else $error("read pointer did not advance");

  assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!ptr_step && !ptr_clr) |=> $stable(ptr))
    else $error("read pointer moved without a size read");

endmodule

// File: rtl/mbs_socket_cfg.sv
module mbs_socket_cfg
  import mbs_pkg::*;
#(
  parameter int SOCKETS = 6,
  parameter int IDX_W   = 3,
  parameter int END_W   = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [END_W-1:0]         wr_end,
  input  logic [END_W-1:0]         start_end,
  input  logic [2*SOCKETS-1:0]     kinds,
  output logic [SOCKETS*END_W-1:0] base,
  output logic [SOCKETS-1:0]       en
);

  for (genvar s = 0; s < SOCKETS; s++) begin : g_sock
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(s + 1)) && kind_present(kinds[2*s +: 2]);

    always_ff @(posedge clk) begin
      if (rst) begin
        base[s*END_W +: END_W] <= '0;
        en[s]                  <= 1'b0;
      end else if (sel) begin
        base[s*END_W +: END_W] <= start_end;
        en[s]                  <= (wr_end != start_end);
      end
    end

    assert_empty_off_R7: assert property (@(posedge clk) disable iff (rst)
      !kind_present(kinds[2*s +: 2]) |=> !en[s])
      else $error("empty socket enabled");
  end

  assert_edge_slot_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_idx == '0 || wr_idx == '1)) |=> ($stable(en) && $stable(base)))
    else $error("edge slot write reconfigured a socket");

  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(en) && $stable(base)))
    else $error("socket config changed without a write");

endmodule

// File: rtl/mbs_hit_decode.sv
module mbs_hit_decode
  import mbs_pkg::*;
#(
  parameter int SOCKETS    = 6,
  parameter int END_W      = 5,
  parameter int ADDR_W     = 28,
  parameter int UNIT_SHIFT = 23,
  parameter int SOCK_W     = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [2*SOCKETS-1:0]     kinds,
  input  logic [SOCKETS*END_W-1:0] base,
  input  logic [SOCKETS-1:0]       en,
  output logic                     hit,
  output logic [SOCK_W-1:0]        hit_sock
);
  localparam int UW = ADDR_W - UNIT_SHIFT;
  localparam int CW = ((UW > END_W) ? UW : END_W) + 2;

  logic [CW-1:0]       unit;
  logic [SOCKETS-1:0]  in_bank;
  logic                any_c;
  logic [SOCK_W-1:0]   sel_c;

  assign unit = CW'(addr[ADDR_W-1:UNIT_SHIFT]);

  for (genvar s = 0; s < SOCKETS; s++) begin : g_cmp
    logic [CW-1:0] lo, hi;
    assign lo = CW'(base[s*END_W +: END_W]);
    assign hi = lo + CW'(kind_units(kinds[2*s +: 2]));
    assign in_bank[s] = en[s] && (unit >= lo) && (unit < hi);
  end

  always_comb begin
    any_c = 1'b0;
    sel_c = '0;
    for (int s = 0; s < SOCKETS; s++) begin
      if (in_bank[s]) begin
        any_c = 1'b1;
        sel_c = SOCK_W'(s);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit      <= 1'b0;
      hit_sock <= '0;
    end else begin
      hit      <= any_c;
      hit_sock <= sel_c;
    end
  end

  assert_hit_enabled_R11: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(en[hit_sock]))
    else $error("hit reported on a disabled bank");

  assert_no_bank_R11: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |=> !hit)
    else $error("hit with every bank disabled");

endmodule

// File: rtl/mem_bank_sizer.sv
module mem_bank_sizer
  import mbs_pkg::*;
#(
  parameter int SOCKETS    = 6,
  parameter int IDX_W      = 3,
  parameter int END_W      = 5,
  parameter int IO_ADDR_W  = 12,
  parameter int ADDR_W     = 28,
  parameter int UNIT_SHIFT = 23,
  parameter logic [11:0] PORT_ID     = 12'h803,
  parameter logic [11:0] PORT_PRES   = 12'h804,
  parameter logic [11:0] PORT_SIZE   = 12'h820,
  parameter logic [11:0] PORT_PARITY = 12'h841,
  parameter logic [7:0]  PARITY_OK   = 8'h01,
  localparam int SOCK_W = (SOCKETS > 1) ? $clog2(SOCKETS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [IO_ADDR_W-1:0]     io_addr,
  input  logic                     io_rd,
  input  logic                     io_wr,
  input  logic [7:0]               io_wdata,
  output logic [7:0]               io_rdata,
  input  logic [2*SOCKETS-1:0]     socket_kind,
  input  logic [ADDR_W-1:0]        lookup_addr,
  output logic [SOCKETS*END_W-1:0] bank_base,
  output logic [SOCKETS-1:0]       bank_en,
  output logic                     hit_valid,
  output logic [SOCK_W-1:0]        hit_socket
);

  logic is_id, is_pres, is_size, is_par;
  logic size_wr;
  logic [IDX_W-1:0] wr_idx;
  logic [END_W-1:0] wr_end, ptr_end, start_end;
  logic [7:0] id_bits, pres_bits, rd_mux;

  assign is_id   = io_addr == IO_ADDR_W'(PORT_ID);
  assign is_pres = io_addr == IO_ADDR_W'(PORT_PRES);
  assign is_size = io_addr == IO_ADDR_W'(PORT_SIZE);
  assign is_par  = io_addr == IO_ADDR_W'(PORT_PARITY);

  assign size_wr = io_wr && is_size;
  assign wr_idx  = io_wdata[7 -: IDX_W];
  assign wr_end  = io_wdata[END_W-1:0];

  always_comb begin
    id_bits   = '0;
    pres_bits = '1;
    for (int s = 0; s < SOCKETS; s++) begin
      if (kind_large(socket_kind[2*s +: 2]))   id_bits[s]   = 1'b1;
      if (kind_present(socket_kind[2*s +: 2])) pres_bits[s] = 1'b0;
    end
  end

  always_comb begin
    if (is_id)        rd_mux = id_bits;
    else if (is_pres) rd_mux = pres_bits;
    else if (is_size) rd_mux = 8'(ptr_end);
    else if (is_par)  rd_mux = PARITY_OK;
    else              rd_mux = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst)        io_rdata <= '0;
    else if (io_rd) io_rdata <= rd_mux;
  end

  mbs_slot_table #(.IDX_W(IDX_W), .END_W(END_W)) u_slots (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (size_wr),
    .wr_idx    (wr_idx),
    .wr_end    (wr_end),
    .ptr_clr   (io_rd && is_pres),
    .ptr_step  (io_rd && is_size),
    .ptr_end   (ptr_end),
    .start_end (start_end)
  );

  mbs_socket_cfg #(.SOCKETS(SOCKETS), .IDX_W(IDX_W), .END_W(END_W)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (size_wr),
    .wr_idx    (wr_idx),
    .wr_end    (wr_end),
    .start_end (start_end),
    .kinds     (socket_kind),
    .base      (bank_base),
    .en        (bank_en)
  );

  mbs_hit_decode #(
    .SOCKETS(SOCKETS), .END_W(END_W), .ADDR_W(ADDR_W),
    .UNIT_SHIFT(UNIT_SHIFT), .SOCK_W(SOCK_W)
  ) u_hit (
    .clk      (clk),
    .rst      (rst),
    .addr     (lookup_addr),
    .kinds    (socket_kind),
    .base     (bank_base),
    .en       (bank_en),
    .hit      (hit_valid),
    .hit_sock (hit_socket)
  );

  assert_parity_const_R8: assert property (@(posedge clk) disable iff (rst)
    (io_rd && is_par) |=> io_rdata == PARITY_OK)
    else $error("parity status not constant");

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !is_id && !is_pres && !is_size && !is_par) |=> io_rdata == 8'h00)
    else $error("unmapped read returned data");

  assert_size_read_upper_R4: assert property (@(posedge clk) disable iff (rst)
    (io_rd && is_size) |=> io_rdata[7:END_W] == '0)
    else $error("size read upper bits set");

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> $stable(io_rdata))
    else $error("read data changed without a read");

endmodule

// File: tb/sim_mem_bank_sizer.sv
module sim_mem_bank_sizer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] io_addr = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  // s5,s4 empty; s3,s2 8 MB; s1,s0 32 MB
  logic [11:0] socket_kind = 12'b00_00_01_01_10_10;
  logic [27:0] lookup_addr = '0;
  logic [29:0] bank_base;
  logic [5:0]  bank_en;
  logic        hit_valid;
  logic [2:0]  hit_socket;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  mem_bank_sizer u0 (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .socket_kind(socket_kind),
    .lookup_addr(lookup_addr), .bank_base(bank_base), .bank_en(bank_en),
    .hit_valid(hit_valid), .hit_socket(hit_socket)
  );

  // {op(1=rd,2=wr), port, wdata, expected rdata, requirement}
  localparam int NV = 29;
  localparam logic [33:0] VEC [NV] = '{
    {2'd1, 12'h803, 8'h00, 8'h03, 4'd1},  // R1 id bits
    {2'd1, 12'h804, 8'h00, 8'hF0, 4'd2},  // R2 presence
    {2'd1, 12'h841, 8'h00, 8'h01, 4'd8},  // R8 parity
    {2'd1, 12'h800, 8'h00, 8'h00, 4'd9},  // R9 unmapped
    {2'd1, 12'h821, 8'h00, 8'h00, 4'd9},  // R9 unmapped
    {2'd2, 12'h820, 8'h24, 8'h00, 4'd5},  // slot1=4
    {2'd2, 12'h820, 8'h48, 8'h00, 4'd5},  // slot2=8
    {2'd2, 12'h820, 8'h69, 8'h00, 4'd5},  // slot3=9
    {2'd2, 12'h820, 8'h89, 8'h00, 4'd5},  // slot4=9
    {2'd2, 12'h820, 8'hAA, 8'h00, 4'd5},  // slot5=10 (empty socket)
    {2'd2, 12'h820, 8'h03, 8'h00, 4'd5},  // slot0=3
    {2'd2, 12'h820, 8'hFF, 8'h00, 4'd5},  // slot7=31
    {2'd2, 12'h803, 8'h55, 8'h00, 4'd9},  // ignored
    {2'd2, 12'h804, 8'h00, 8'h00, 4'd9},  // ignored
    {2'd1, 12'h804, 8'h00, 8'hF0, 4'd3},  // R3 pointer clear
    {2'd1, 12'h820, 8'h00, 8'h03, 4'd4},  // R4/R5 walk
    {2'd1, 12'h820, 8'h00, 8'h04, 4'd4},
    {2'd1, 12'h820, 8'h00, 8'h08, 4'd4},
    {2'd1, 12'h820, 8'h00, 8'h09, 4'd4},
    {2'd1, 12'h820, 8'h00, 8'h09, 4'd4},
    {2'd1, 12'h820, 8'h00, 8'h0A, 4'd5},
    {2'd1, 12'h820, 8'h00, 8'h00, 4'd5},
    {2'd1, 12'h820, 8'h00, 8'h1F, 4'd5},
    {2'd1, 12'h820, 8'h00, 8'h03, 4'd4},  // R4 wrap
    {2'd1, 12'h820, 8'h00, 8'h04, 4'd4},
    {2'd1, 12'h804, 8'h00, 8'hF0, 4'd3},
    {2'd1, 12'h820, 8'h00, 8'h03, 4'd3},  // R3 mid-walk clear
    {2'd1, 12'h803, 8'h00, 8'h03, 4'd9},  // R9 id unchanged by write
    {2'd1, 12'h841, 8'h00, 8'h01, 4'd8}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic io_read(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    @(negedge clk); io_rd = 1'b0; d = io_rdata;
  endtask

  task automatic io_write(input logic [11:0] a, input logic [7:0] v);
    @(negedge clk); io_addr = a; io_wdata = v; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic look(input int unit, input int off, input bit ev, input int es, input string req);
    @(negedge clk); lookup_addr = 28'(unit) << 23 | 28'(off);
    @(negedge clk);
    check(req, hit_valid, ev);
    if (ev) check(req, hit_socket, es);
  endtask

  task automatic bank(input int s, input int eb, input bit ee, input string req);
    check(req, bank_base[s*5 +: 5], eb);
    check(req, bank_en[s], ee);
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check("R10", io_rdata, 0);
    check("R10", bank_en, 0);
    check("R10", hit_valid, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][33:32] == 2'd1) begin
        io_read(VEC[i][31:20], d);
        check($sformatf("R%0d vec%0d", VEC[i][3:0], i), d, VEC[i][11:4]);
      end else begin
        io_write(VEC[i][31:20], VEC[i][19:12]);
      end
    end

    // R6 bases/enables; R7 slot0/slot7/empty-socket writes left things alone
    bank(0, 0, 1, "R6 s0");
    bank(1, 4, 1, "R6 s1");
    bank(2, 8, 1, "R6 s2");
    bank(3, 9, 0, "R6 s3 end==start");
    bank(4, 0, 0, "R7 s4 empty");
    bank(5, 0, 0, "R7 s5 empty");

    // R11 decode
    look(5, 100, 1, 1, "R11 inside s1");
    look(3, 28'h7FFFFF, 1, 0, "R11 last unit s0");
    look(4, 0, 1, 1, "R11 first unit s1");
    look(8, 5, 1, 2, "R11 s2");
    look(9, 0, 0, 0, "R11 disabled s3");
    look(12, 0, 0, 0, "R11 no bank");

    // overlap: s0 0..3, s1 2..5
    io_write(12'h820, 8'h22);
    io_write(12'h820, 8'h46);
    bank(0, 0, 1, "R6 s0 re");
    bank(1, 2, 1, "R6 s1 re");
    look(2, 0, 1, 1, "R11 priority");
    look(1, 0, 1, 0, "R11 s0 only");

    // R10 reset again mid-use
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10", bank_en, 0);
    check("R10", bank_base, 0);
    check("R10", io_rdata, 0);
    check("R10", hit_valid, 0);
    io_read(12'h820, d);
    check("R10 slot0", d, 0);
    io_read(12'h820, d);
    check("R10 slot1", d, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule